// File: doc/BRIEF.md
# Windowed Antipodal Bit Correlation Matrix

This block maintains the auto-correlation matrix of a vector of antipodal bits accumulated over a sliding window. A bit at logic 1 stands for +1 and a bit at logic 0 stands for -1. The product of two such bits is therefore an XNOR, and each matrix entry is a small up/down counter instead of a multiply-accumulate. Each accepted update adds the outer product of the newest bit vector. While the window is full, the same update also removes the outer product of the vector that is leaving the window. The caller keeps the history of past vectors and presents the leaving vector alongside the new one.

The new vector is taken either from pilot (training) bits or from detected bits, so that a channel estimator can keep tracking in decision-feedback mode once training ends. The matrix is symmetric, so only the upper triangle including the diagonal is stored. All of these counters are updated together in one clock cycle. A registered read port returns any (row, column) entry, and reads of the lower triangle are mirrored onto the stored upper triangle. A synchronous clear zeroes the matrix when a new training window starts.

Top module: `ac_window_corr`

## Requirements
- R1: Bit value 1 means +1 and bit value 0 means -1. The product for entry (i,j) is +1 when bits i and j are equal and -1 when they differ. Bit i is bit position i of the vector.
- R2: An accepted update with `old_valid` low adds the new product to every entry. Each entry therefore moves by +1 or -1.
- R3: An accepted update with `old_valid` high adds the new product and subtracts the old product. An entry whose two products are equal keeps its value, and otherwise it moves by +2 or -2.
- R4: A diagonal entry rises by exactly 1 on an update with `old_valid` low. It keeps its value on an update with `old_valid` high.
- R5: The new vector is `pilot_bits` when `track_mode` is 0 and `det_bits` when `track_mode` is 1. The unselected source has no effect on the matrix.
- R6: All entries change in the same clock edge that accepts the update. `done` is high for exactly the one cycle after each accepted update.
- R7: With `clear` high, every entry becomes 0 at the next edge, even if `upd_valid` is also high. That cycle does not count as an update, so `done` stays low after it.
- R8: `rd_data` is registered. One edge after `rd_row`/`rd_col` are presented, it holds the value the entry had before that edge. A read with row > column returns entry (column, row).
- R9: While `rst` is high, all entries, `rd_data` and `done` are 0.
- R10: Entries are CW-bit two's-complement values that wrap modulo 2^CW.
- R11: With `upd_valid` low and `clear` low, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zero the matrix at the start of a new window |
| upd_valid | input | 1 | Apply one update this cycle |
| track_mode | input | 1 | 0: pilot bits, 1: detected bits |
| pilot_bits | input | NB | Training bit vector |
| det_bits | input | NB | Decision-feedback bit vector |
| old_bits | input | NB | Vector leaving the window |
| old_valid | input | 1 | The window is full, so remove `old_bits` |
| rd_row | input | RW | Read row index |
| rd_col | input | RW | Read column index |
| rd_data | output | CW | Entry value, two's complement |
| done | output | 1 | One-cycle strobe after each update |

## Verification
The bench targets the following cases:

- **Sliding cancellation.** Updates whose new and old products match must leave entries alone. A design that always adds and subtracts one unit would drift.
- **Diagonal entries.** On a sliding update the diagonal must hold still. A design that computes an XNOR for the diagonal but takes the old vector wrongly would move it.
- **Clear against update.** When a clear and an update arrive together, a design that lets the update win would leave nonzero entries and raise `done`.
- **Other paths.** The bench also reads mirrored lower-triangle entries, switches the source multiplexer while the unselected input keeps changing, and drives one entry past 2^CW so that saturating or sign-broken counters diverge.

// File: rtl/ac_corr_pkg.sv
package ac_corr_pkg;
  // Flat index of stored entry (i,j), i <= j, in a row-major upper triangle.
  function automatic int tri_idx(input int n, input int i, input int j);
    return i * n - (i * (i - 1)) / 2 + (j - i);
  endfunction

  function automatic int tri_count(input int n);
    return (n * (n + 1)) / 2;
  endfunction
endpackage

// File: rtl/ac_src_mux.sv
module ac_src_mux #(
  parameter int NB = 8
) (
  input  logic          track_mode,
  input  logic [NB-1:0] pilot_bits,
  input  logic [NB-1:0] det_bits,
  output logic [NB-1:0] new_bits
);
  always_comb begin
    new_bits = track_mode ? det_bits : pilot_bits;
  end
endmodule

// File: rtl/ac_cell.sv
module ac_cell #(
  parameter int CW   = 8,
  parameter bit DIAG = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          upd,
  input  logic          old_vld,
  input  logic          nb_i,
  input  logic          nb_j,
  input  logic          ob_i,
  input  logic          ob_j,
  output logic [CW-1:0] cnt
);
  logic pn, po;

  generate
    if (DIAG) begin : g_diag
      // a bit times itself is always +1
      assign pn = 1'b1;
      assign po = 1'b1;
    end else begin : g_pair
      assign pn = ~(nb_i ^ nb_j);
      assign po = ~(ob_i ^ ob_j);
    end
  endgenerate

  logic [CW-1:0] step;
  always_comb begin
    step = '0;
    if (!old_vld)
      step = pn ? CW'(1) : '1;
    else if (pn != po)
      step = pn ? CW'(2) : CW'(-2);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (upd)
      cnt <= cnt + step;
  end

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !upd) |=> $stable(cnt));

  generate
    if (DIAG) begin : g_diag_chk
      a_r4_diag_slide: assert property (@(posedge clk) disable iff (rst)
        (!clr && upd && old_vld) |=> $stable(cnt));
      a_r4_diag_step: assert property (@(posedge clk) disable iff (rst)
        (!clr && upd && !old_vld) |=> (cnt == CW'($past(cnt) + 1'b1)));
    end else begin : g_pair_chk
      a_r3_cancel: assert property (@(posedge clk) disable iff (rst)
        (!clr && upd && old_vld && (nb_i ~^ nb_j) == (ob_i ~^ ob_j)) |=> $stable(cnt));
    end
  endgenerate
endmodule

// File: rtl/ac_read_port.sv
module ac_read_port #(
  parameter int NB   = 8,
  parameter int CW   = 8,
  parameter int RW   = 3,
  parameter int NENT = 36
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RW-1:0]      row,
  input  logic [RW-1:0]      col,
  input  logic [NENT*CW-1:0] ent_flat,
  output logic [CW-1:0]      rd_data
);
  import ac_corr_pkg::*;

  logic [CW-1:0] sel;
  always_comb begin
    int lo, hi, idx;
    lo  = (row <= col) ? int'(row) : int'(col);
    hi  = (row <= col) ? int'(col) : int'(row);
    idx = tri_idx(NB, lo, hi);
    sel = '0;
    if (hi < NB)
      for (int k = 0; k < NENT; k++)
        if (k == idx) sel = ent_flat[k*CW +: CW];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end
endmodule

// File: rtl/ac_window_corr.sv
module ac_window_corr #(
  parameter int NB = 8,
  parameter int CW = 8,
  parameter int RW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          upd_valid,
  input  logic          track_mode,
  input  logic [NB-1:0] pilot_bits,
  input  logic [NB-1:0] det_bits,
  input  logic [NB-1:0] old_bits,
  input  logic          old_valid,
  input  logic [RW-1:0] rd_row,
  input  logic [RW-1:0] rd_col,
  output logic [CW-1:0] rd_data,
  output logic          done
);
  import ac_corr_pkg::*;

  localparam int NENT = tri_count(NB);

  logic [NB-1:0]      new_bits;
  logic [NENT*CW-1:0] ent_flat;

  ac_src_mux #(.NB(NB)) u_mux (
    .track_mode(track_mode),
    .pilot_bits(pilot_bits),
    .det_bits  (det_bits),
    .new_bits  (new_bits)
  );

  for (genvar i = 0; i < NB; i++) begin : g_row
    for (genvar j = i; j < NB; j++) begin : g_col
      localparam int IDX = tri_idx(NB, i, j);
      ac_cell #(.CW(CW), .DIAG(i == j)) u_cell (
        .clk    (clk),
        .rst    (rst),
        .clr    (clear),
        .upd    (upd_valid),
        .old_vld(old_valid),
        .nb_i   (new_bits[i]),
        .nb_j   (new_bits[j]),
        .ob_i   (old_bits[i]),
        .ob_j   (old_bits[j]),
        .cnt    (ent_flat[IDX*CW +: CW])
      );
    end
  end

  ac_read_port #(.NB(NB), .CW(CW), .RW(RW), .NENT(NENT)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .row     (rd_row),
    .col     (rd_col),
    .ent_flat(ent_flat),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= upd_valid && !clear;
  end

  a_r6_done_after_update: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !clear) |=> done);
  a_r7_no_done_otherwise: assert property (@(posedge clk) disable iff (rst)
    !(upd_valid && !clear) |=> !done);
endmodule

// File: tb/ac_window_corr_test.sv
module ac_window_corr_test;
  localparam int NB = 8;
  localparam int CW = 8;
  localparam int RW = 3;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, clear = 1'b0, upd_valid = 1'b0, track_mode = 1'b0, old_valid = 1'b0;
  logic [NB-1:0] pilot_bits = '0, det_bits = '0, old_bits = '0;
  logic [RW-1:0] rd_row = '0, rd_col = '0;
  logic [CW-1:0] rd_data;
  logic done;

  ac_window_corr #(.NB(NB), .CW(CW), .RW(RW)) uut (
    .clk(clk), .rst(rst), .clear(clear), .upd_valid(upd_valid),
    .track_mode(track_mode), .pilot_bits(pilot_bits), .det_bits(det_bits),
    .old_bits(old_bits), .old_valid(old_valid), .rd_row(rd_row),
    .rd_col(rd_col), .rd_data(rd_data), .done(done)
  );

  int m [NB][NB];
  int exp_rd = 0;
  bit exp_done = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // behavioural reference: full symmetric matrix of integers
  always @(posedge clk) begin
    if (rst) begin
      foreach (m[a, b]) m[a][b] = 0;
      exp_rd = 0; exp_done = 1'b0;
    end else begin
      logic [NB-1:0] nb;
      exp_rd = m[rd_row][rd_col];
      exp_done = upd_valid && !clear;
      nb = track_mode ? det_bits : pilot_bits;
      if (clear) begin
        foreach (m[a, b]) m[a][b] = 0;
      end else if (upd_valid) begin
        foreach (m[a, b]) begin
          int pn, po, d;
          pn = (nb[a] == nb[b]) ? 1 : -1;
          po = (old_bits[a] == old_bits[b]) ? 1 : -1;
          d  = old_valid ? pn - po : pn;
          m[a][b] = (m[a][b] + d) & MASK;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    chk(int'(rd_data) == exp_rd, {tag, " rd_data"}, int'(rd_data), exp_rd);
    chk(done == exp_done, "R6 done strobe", int'(done), int'(exp_done));
  endtask

  task automatic drive(input bit u, input bit ov, input bit tm);
    upd_valid = u; old_valid = ov; track_mode = tm;
    pilot_bits = NB'($urandom); det_bits = NB'($urandom); old_bits = NB'($urandom);
    rd_row = RW'($urandom); rd_col = RW'($urandom);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int k = 0; k < 3; k++) step("R9 reset");
    rst = 1'b0;
    // R1: known pattern, bits 0 and 1 equal (+1), bit 2 differs (-1)
    upd_valid = 1'b1; pilot_bits = 8'b0000_0011; rd_row = 0; rd_col = 1;
    step("R9 reset");
    upd_valid = 1'b0; rd_row = 0; rd_col = 2;
    step("R1 equal bits +1");
    rd_row = 2; rd_col = 0;
    step("R1 unequal bits -1");
    step("R8 mirrored read");
    // R2: add-only updates from pilot bits
    for (int k = 0; k < 20; k++) begin drive(1, 0, 0); step("R2 add-only"); end
    // R5: tracking from detected bits, pilot keeps toggling
    for (int k = 0; k < 20; k++) begin drive(1, 0, 1); step("R5 source select"); end
    // R3: sliding updates with old vector
    for (int k = 0; k < 40; k++) begin drive(1'($urandom), 1, 1'($urandom)); step("R3 sliding"); end
    // R3: old equals new: every entry must cancel
    for (int k = 0; k < 8; k++) begin
      drive(1, 1, 0); old_bits = pilot_bits; step("R3 cancel");
    end
    // R4: diagonal reads across add-only and sliding updates
    for (int k = 0; k < 24; k++) begin
      drive(1, 1'($urandom), 0); rd_col = rd_row; step("R4 diagonal");
    end
    // R8: lower-triangle reads
    for (int k = 0; k < 24; k++) begin
      drive(1'($urandom), 1'($urandom), 0);
      rd_row = RW'(1 + ($urandom % (NB - 1))); rd_col = RW'($urandom % rd_row);
      step("R8 lower triangle");
    end
    // R11: idle cycles
    for (int k = 0; k < 10; k++) begin drive(0, 1'($urandom), 0); step("R11 idle"); end
    // R7: clear together with update
    drive(1, 0, 0); clear = 1'b1; step("R7 clear");
    clear = 1'b0; drive(0, 0, 0);
    for (int k = 0; k < 6; k++) begin rd_row = RW'(k); rd_col = RW'(k + 1); step("R7 cleared"); end
    // R10: drive entries past 2^CW with a constant pattern
    for (int k = 0; k < 300; k++) begin
      drive(1, 0, 0); pilot_bits = 8'b1010_0110; rd_row = 0; rd_col = RW'(k % NB);
      step("R10 wrap");
    end
    drive(0, 0, 0); rd_row = 1; rd_col = 2;
    step("R10 wrap");
    step("R10 wrap final");
    summary();
  end
endmodule